// File: doc/BRIEF.md
# Maskable Interrupt Priority Controller

This block gathers trigger pulses from a parameterised number of interrupt sources and turns them into one request to the CPU, together with the vector number of the source to serve. Each source has a small control word with a pending flag, an enable and a 2-bit priority level. A status word holds the CPU mask level, a global enable, a bit that allows nested servicing, and a bit that allows software to write the pending flags. Software writes to a pending flag are dropped unless that bit is set.

When the CPU accepts a request, the block clears that source's pending flag. It saves the current mask level on a small internal stack and loads the accepted level as the new mask. An interrupt-return pulse pops the saved level back. While a handler runs and nesting is not allowed, no further request is raised until return.

Level 0 is the most urgent. A source can only be served when its level is numerically below the current mask, so a mask of 3 admits levels 0 to 2 and a mask of 0 admits nothing.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every source word reads 0, the status word reads 0x03 (mask 3, all enables 0) and `irq_req_o` is 0.
- R2: A write or read at address i (i below NUM_SRC) reaches source i, whose word is {pending[3], enable[2], level[1:0]}. Address NUM_SRC holds the status word {flag_write_en[4], nest_en[3], global_en[2], mask[1:0]}. Other addresses read 0.
- R3: A trigger pulse on `trig_i[i]` sets pending flag i in the next cycle.
- R4: A software write to a source word always updates enable and level. It changes the pending flag only while flag_write_en is 1; otherwise the flag keeps its value.
- R5: While global_en is 0, `irq_req_o` is 0.
- R6: A source is eligible only when its pending flag is 1, its enable is 1 and its level is numerically below the mask.
- R7: Among eligible sources the lowest level wins, and ties go to the lowest index. The winner's index appears on `irq_vec_o` while `irq_req_o` is 1.
- R8: An `irq_ack_i` while `irq_req_o` is 1 clears the winner's pending flag, saves the mask and loads the winner's level as the mask. An `irq_ack_i` while `irq_req_o` is 0 has no effect.
- R9: `irq_ret_i` restores the most recently saved mask. With nothing saved it has no effect. In the same cycle as an accept, the return is taken and the accept is dropped.
- R10: While at least one accept is unreturned and nest_en is 0, `irq_req_o` is 0. With nest_en 1, a request whose level beats the loaded mask is raised.
- R11: When a trigger and an accept-clear hit the same source in one cycle, the pending flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | NUM_SRC | One-cycle trigger pulse per source |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | REG_W | Register write data |
| reg_rdata_o | output | REG_W | Register read data, combinational |
| irq_req_o | output | 1 | Interrupt request to CPU |
| irq_vec_o | output | IDX_W | Index of winning source |
| irq_ack_i | input | 1 | CPU accepts current request |
| irq_ret_i | input | 1 | CPU returns from handler |

## Verification
The trigger that sets a source's pending flag and the accept that clears it can land in the same cycle. The bench provokes this by pulsing the serving source's trigger on the same clock as `irq_ack_i`. It then judges the result at the ports: the source word must still read pending, the mask must have moved to the accepted level, and after a return the same source must be requested again. Accept and return in one cycle, and an accept with no request raised, are driven the same way and judged through the status word.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W    = 2;
  localparam int NEST_MAX = (1 << LVL_W) - 1;  // strictly falling levels bound depth
  typedef logic [LVL_W-1:0] lvl_t;

  // status word bit positions
  localparam int ST_GEN  = LVL_W;
  localparam int ST_NEST = LVL_W + 1;
  localparam int ST_RWE  = LVL_W + 2;
endpackage

// File: rtl/irq_src_reg.sv
module irq_src_reg
  import irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic hw_clr_i,
  input  logic sw_wr_i,
  input  logic rwe_i,
  input  logic [LVL_W+1:0] wdata_i,
  output logic ir_o,
  output logic ie_o,
  output lvl_t lv_o
);
  logic ir_q, ie_q;
  lvl_t lv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q <= 1'b0;
      ie_q <= 1'b0;
      lv_q <= '0;
    end else begin
      if (trig_i)                ir_q <= 1'b1;  // trigger beats clear
      else if (hw_clr_i)         ir_q <= 1'b0;
      else if (sw_wr_i && rwe_i) ir_q <= wdata_i[LVL_W+1];
      if (sw_wr_i) begin
        ie_q <= wdata_i[LVL_W];
        lv_q <= wdata_i[LVL_W-1:0];
      end
    end
  end

  assign ir_o = ir_q;
  assign ie_o = ie_q;
  assign lv_o = lv_q;

  a_r3_trig_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> ir_q);
  a_r8_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_clr_i && !trig_i) |=> !ir_q);
  a_r4_sw_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_wr_i && !rwe_i && !trig_i && !hw_clr_i) |=> ir_q == $past(ir_q));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] ir_i,
  input  logic [NUM_SRC-1:0] ie_i,
  input  lvl_t               lv_i [NUM_SRC],
  input  lvl_t               mask_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   vec_o,
  output lvl_t               win_lv_o
);
  logic [NUM_SRC-1:0] elig;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++)
      elig[i] = ir_i[i] & ie_i[i] & (lv_i[i] < mask_i);
  end

  // strict compare keeps the lowest index on equal levels
  always_comb begin
    valid_o  = 1'b0;
    vec_o    = '0;
    win_lv_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!valid_o || lv_i[i] < win_lv_o)) begin
        valid_o  = 1'b1;
        vec_o    = IDX_W'(i);
        win_lv_o = lv_i[i];
      end
    end
  end

  a_r7_vec_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (ir_i[vec_o] && ie_i[vec_o]));
  a_r6_below_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (lv_i[vec_o] < mask_i));
endmodule

// File: rtl/irq_mask_stack.sv
module irq_mask_stack
  import irq_pkg::*;
#(
  parameter int DEPTH = NEST_MAX,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  lvl_t             din_i,
  output lvl_t             top_o,
  output logic [CNT_W-1:0] cnt_o
);
  lvl_t             mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (pop_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (push_i && cnt_q < CNT_W'(DEPTH)) begin
      mem_q[cnt_q] <= din_i;
      cnt_q        <= cnt_q + 1'b1;
    end
  end

  assign top_o = (cnt_q == '0) ? '0 : mem_q[cnt_q - 1'b1];
  assign cnt_o = cnt_q;

  a_r8_push_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> cnt_q < CNT_W'(DEPTH));
  a_r9_pop_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int REG_W   = 8,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int ADDR_W = $clog2(NUM_SRC + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] trig_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic               irq_req_o,
  output logic [IDX_W-1:0]   irq_vec_o,
  input  logic               irq_ack_i,
  input  logic               irq_ret_i
);
  localparam int CNT_W = $clog2(NEST_MAX + 1);

  logic [NUM_SRC-1:0] ir, ie, src_wr, hw_clr;
  lvl_t               lv [NUM_SRC];
  lvl_t               mask_q, win_lv, stk_top;
  logic               gen_q, nest_q, rwe_q;
  logic               win_valid, in_service, gen_eff, acc_ok, ret_ok, st_wr;
  logic [IDX_W-1:0]   win_idx;
  logic [CNT_W-1:0]   depth;

  assign st_wr      = reg_wr_i && (reg_addr_i == ADDR_W'(NUM_SRC));
  assign in_service = (depth != '0);
  assign gen_eff    = gen_q & ~(in_service & ~nest_q);
  assign irq_req_o  = win_valid & gen_eff;
  assign irq_vec_o  = win_idx;
  assign ret_ok     = irq_ret_i & in_service;
  assign acc_ok     = irq_ack_i & irq_req_o & ~irq_ret_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign src_wr[g] = reg_wr_i && (reg_addr_i == ADDR_W'(g));
    assign hw_clr[g] = acc_ok && (win_idx == IDX_W'(g));
    irq_src_reg u_src (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .trig_i   (trig_i[g]),
      .hw_clr_i (hw_clr[g]),
      .sw_wr_i  (src_wr[g]),
      .rwe_i    (rwe_q),
      .wdata_i  (reg_wdata_i[LVL_W+1:0]),
      .ir_o     (ir[g]),
      .ie_o     (ie[g]),
      .lv_o     (lv[g])
    );
  end

  irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ir_i     (ir),
    .ie_i     (ie),
    .lv_i     (lv),
    .mask_i   (mask_q),
    .valid_o  (win_valid),
    .vec_o    (win_idx),
    .win_lv_o (win_lv)
  );

  irq_mask_stack #(.DEPTH(NEST_MAX)) u_stk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (acc_ok),
    .pop_i  (ret_ok),
    .din_i  (mask_q),
    .top_o  (stk_top),
    .cnt_o  (depth)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      gen_q  <= 1'b0;
      nest_q <= 1'b0;
      rwe_q  <= 1'b0;
    end else begin
      if (ret_ok)      mask_q <= stk_top;
      else if (acc_ok) mask_q <= win_lv;
      else if (st_wr)  mask_q <= reg_wdata_i[LVL_W-1:0];
      if (st_wr) begin
        gen_q  <= reg_wdata_i[ST_GEN];
        nest_q <= reg_wdata_i[ST_NEST];
        rwe_q  <= reg_wdata_i[ST_RWE];
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(NUM_SRC)) begin
      reg_rdata_o[LVL_W-1:0] = mask_q;
      reg_rdata_o[ST_GEN]    = gen_q;
      reg_rdata_o[ST_NEST]   = nest_q;
      reg_rdata_o[ST_RWE]    = rwe_q;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (reg_addr_i == ADDR_W'(i))
          reg_rdata_o[LVL_W+1:0] = {ir[i], ie[i], lv[i]};
      end
    end
  end

  a_r5_gen_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_q |-> !irq_req_o);
  a_r8_accept_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok |=> mask_q == $past(win_lv));
  a_r9_ret_restores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_ok |=> mask_q == $past(stk_top));
  a_r10_no_nest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_service && !nest_q) |-> !irq_req_o);
endmodule

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
  localparam int NUM_SRC = 8;
  localparam int REG_W   = 8;
  localparam int IDX_W   = 3;
  localparam int ADDR_W  = 4;
  localparam logic [ADDR_W-1:0] ST = ADDR_W'(NUM_SRC);

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NUM_SRC-1:0] trig = '0;
  logic               wr = 1'b0;
  logic [ADDR_W-1:0]  addr = '0;
  logic [REG_W-1:0]   wdata = '0;
  logic [REG_W-1:0]   rdata;
  logic               req;
  logic [IDX_W-1:0]   vec;
  logic               ack = 1'b0;
  logic               ret = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  irq_prio_ctrl #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_req_o(req), .irq_vec_o(vec), .irq_ack_i(ack), .irq_ret_i(ret)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [ADDR_W-1:0] a, output int d);
    addr = a;
    #1;
    d = int'(rdata);
  endtask

  // one cycle of strobes, state settled at the following negedge
  task automatic pulse(input logic [NUM_SRC-1:0] t, input logic a, input logic r);
    @(negedge clk);
    trig = t; ack = a; ret = r;
    @(negedge clk);
    trig = '0; ack = 1'b0; ret = 1'b0;
  endtask

  task automatic t_reset();
    int d;
    rd_reg(4'd0, d); check("R1 src0 reset", d, 0);
    rd_reg(4'd7, d); check("R1 src7 reset", d, 0);
    rd_reg(ST, d);   check("R1 status reset", d, 8'h03);
    check("R1 req reset", int'(req), 0);
    rd_reg(4'd9, d); check("R2 unmapped reads 0", d, 0);
  endtask

  task automatic t_sw_write();
    int d;
    wr_reg(4'd2, 8'h0F);
    rd_reg(4'd2, d); check("R4 flag write blocked", d, 8'h07);
    wr_reg(ST, 8'h13);
    wr_reg(4'd2, 8'h0D);
    rd_reg(4'd2, d); check("R4 flag write allowed set", d, 8'h0D);
    wr_reg(4'd2, 8'h05);
    rd_reg(4'd2, d); check("R4 flag write allowed clear", d, 8'h05);
    wr_reg(ST, 8'h03);
    rd_reg(ST, d);   check("R2 status readback", d, 8'h03);
  endtask

  task automatic t_arbitrate();
    int d;
    wr_reg(4'd1, 8'h06);
    wr_reg(4'd3, 8'h05);
    wr_reg(4'd5, 8'h05);
    pulse(8'b0010_1010, 1'b0, 1'b0);
    rd_reg(4'd3, d); check("R3 trigger sets flag", d, 8'h0D);
    check("R5 no req with global off", int'(req), 0);
    wr_reg(ST, 8'h07);
    check("R7 req raised", int'(req), 1);
    check("R7 tie to lowest index", int'(vec), 3);
  endtask

  task automatic t_accept_return();
    int d;
    pulse('0, 1'b1, 1'b0);
    rd_reg(4'd3, d); check("R8 accept clears flag", d, 8'h05);
    rd_reg(ST, d);   check("R8 mask loaded", d, 8'h05);
    check("R10 no req while serving", int'(req), 0);
    pulse('0, 1'b0, 1'b1);
    rd_reg(ST, d);   check("R9 mask restored", d, 8'h07);
    check("R7 next winner vec", int'(vec), 5);
    check("R7 next winner req", int'(req), 1);
  endtask

  task automatic t_nesting();
    int d;
    wr_reg(ST, 8'h0F);
    wr_reg(4'd0, 8'h04);
    pulse('0, 1'b1, 1'b0);
    rd_reg(ST, d); check("R8 nest mask 1", d, 8'h0D);
    check("R6 level2 blocked by mask1", int'(req), 0);
    pulse(8'b0000_0001, 1'b0, 1'b0);
    check("R10 nested req raised", int'(req), 1);
    check("R10 nested vec", int'(vec), 0);
    pulse('0, 1'b1, 1'b0);
    rd_reg(ST, d); check("R8 nest mask 0", d, 8'h0C);
    pulse('0, 1'b0, 1'b1);
    rd_reg(ST, d); check("R9 pop to 1", d, 8'h0D);
    pulse('0, 1'b0, 1'b1);
    rd_reg(ST, d); check("R9 pop to 3", d, 8'h0F);
    check("R7 src1 wins after return", int'(vec), 1);
    pulse('0, 1'b0, 1'b1);
    rd_reg(ST, d); check("R9 return with empty stack ignored", d, 8'h0F);
  endtask

  task automatic t_gating();
    int d;
    wr_reg(ST, 8'h0B);
    check("R5 global off blocks", int'(req), 0);
    wr_reg(ST, 8'h0E);
    check("R6 mask 2 blocks level 2", int'(req), 0);
    pulse('0, 1'b1, 1'b0);
    rd_reg(ST, d);   check("R8 ack without req keeps mask", d, 8'h0E);
    rd_reg(4'd1, d); check("R8 ack without req keeps flag", d, 8'h0E);
    wr_reg(ST, 8'h0F);
    check("R6 mask 3 passes level 2", int'(req), 1);
  endtask

  task automatic t_same_cycle();
    int d;
    pulse(8'b0000_0010, 1'b1, 1'b0);
    rd_reg(4'd1, d); check("R11 trigger beats clear", d, 8'h0E);
    rd_reg(ST, d);   check("R11 accept still loads mask", d, 8'h0E);
    pulse('0, 1'b1, 1'b1);
    rd_reg(ST, d);   check("R9 return beats accept", d, 8'h0F);
    rd_reg(4'd1, d); check("R9 dropped accept keeps flag", d, 8'h0E);
    check("R11 source requested again", int'(vec), 1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sw_write();
    t_arbitrate();
    t_accept_return();
    t_nesting();
    t_gating();
    t_same_cycle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule